// File: doc/BRIEF.md
# Teleprinter Frame Transmitter with Idle Fill

This block turns 5-bit teleprinter characters into asynchronous frames on a single serial line. Each frame is a space start bit, five data bits sent least significant bit first, and a mark stop pulse. The stop pulse need not be a whole number of bits. It can be 1.0, 1.42, 1.5 or 2.0 bit times. The 1.42 setting suits mechanical receivers, and 1.0 should not be used when a mechanical machine is at the far end.

All timing comes from an internal sub-bit tick. The tick divides the system clock down to one hundredth of a bit period. The default divider gives 45 baud from a 100 MHz clock. Characters enter through a valid/ready handshake and are accepted only on a frame boundary, so a frame is never cut short.

When idle fill is enabled and no character is offered at the end of a frame, the block sends a fill character straight away. The line then gets a fresh start transition every character cycle. When fill is off and nothing is pending, the line rests at mark.

Top module: `tty_fill_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `line_out` is mark (1), `busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit of space (0) lasting 100 sub-bit ticks, then `in_data[0]` through `in_data[4]` (least significant bit first), 100 ticks each, then a mark stop pulse.
- R3: The stop pulse lasts 100, 142, 150 or 200 ticks for `stop_sel` = 00, 01, 10, 11. When another frame follows, its start edge comes right after the stop pulse, so start-to-start spacing is (600 + stop ticks) × `CLK_DIV` clock cycles.
- R4: `stop_sel` is sampled when a frame is launched. Changing it mid-frame does not alter that frame's stop pulse.
- R5: A character is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. If the block was idle, the start bit begins at that edge and `busy` rises with it.
- R6: During a frame, `in_ready` stays 0 except in the final clock of the stop pulse. A character offered mid-frame waits, and no frame is truncated.
- R7: With `fill_en` = 1 and no valid character at a frame boundary (idle or end of stop), the block launches the fill character 5'b11111 at once.
- R8: At a frame boundary, an offered user character takes precedence over the fill character.
- R9: With `fill_en` = 0 and nothing offered, `busy` falls at the end of the current stop pulse and the line stays mark. No further frame is sent.
- R10: One sub-bit tick lasts `CLK_DIV` clock cycles. The default of 22222 gives 45 baud at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 5 | Character code to transmit |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken this cycle |
| stop_sel | input | 2 | Stop pulse length: 00=1.0, 01=1.42, 10=1.5, 11=2.0 bits |
| fill_en | input | 1 | Send fill characters when nothing is offered |
| line_out | output | 1 | Serial line, 1 = mark |
| busy | output | 1 | A frame is in progress |

## Verification
Character patterns are sent with alternating bits (10101, 01010) and with skewed bit patterns (00001, 11110, 00111, 11000, 10010). These catch a swapped bit order or a shift that stalls or slips.

The patterns are sent back to back under each stop setting. The measured start-to-start spacing separates 100, 142, 150 and 200 tick stop pulses from one another, and also tells a correct divider from a wrong one.

In one sequence `stop_sel` changes mid-frame. This shows whether the setting is latched at launch or read live.

With fill enabled, a user character is inserted between fill frames and fill is then switched off. This shows the fill code, that user data wins at the boundary, that the line never rests in the stop state while fill is on, and that the line falls quiet once fill is off.

// File: rtl/tty_fill_tx_pkg.sv
package tty_fill_tx_pkg;

  localparam int CHAR_W      = 5;
  localparam int SUB_PER_BIT = 100;
  localparam int SUB_W       = 8;
  localparam int BIT_IDX_W   = 3;
  localparam logic [CHAR_W-1:0] FILL_CODE = 5'b11111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // stop pulse length in sub-bit ticks for a given select code
  function automatic logic [SUB_W-1:0] stop_ticks(input logic [1:0] sel);
    logic [SUB_W-1:0] n;
    case (sel)
      2'b00:   n = 8'd100;
      2'b01:   n = 8'd142;
      2'b10:   n = 8'd150;
      default: n = 8'd200;
    endcase
    return n;
  endfunction

  // last sub-bit index of a data or start bit
  function automatic logic [SUB_W-1:0] bit_last();
    return SUB_W'(SUB_PER_BIT - 1);
  endfunction

endpackage

// File: rtl/tty_fill_tick_gen.sv
module tty_fill_tick_gen #(
  parameter int CLK_DIV = 22222
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tty_fill_char_select.sv
module tty_fill_char_select
  import tty_fill_tx_pkg::*;
(
  input  logic              boundary,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              fill_en,
  output logic              launch,
  output logic [CHAR_W-1:0] next_char
);
  // user data wins over fill at a boundary
  always_comb begin
    next_char = in_valid ? in_data : FILL_CODE;
    launch    = boundary && (in_valid || fill_en);
  end
endmodule

// File: rtl/tty_fill_frame_seq.sv
module tty_fill_frame_seq
  import tty_fill_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  logic [CHAR_W-1:0] next_char,
  input  logic [1:0]        stop_sel,
  output logic              line_out,
  output logic              busy,
  output logic              boundary,
  output logic              frame_end,
  output logic              idle_launch
);
  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(CHAR_W - 1);

  tx_state_e               state;
  logic [SUB_W-1:0]        sub;
  logic [SUB_W-1:0]        stop_len;
  logic [BIT_IDX_W-1:0]    bit_idx;
  logic [CHAR_W-1:0]       shreg;
  logic                    bit_done;

  assign bit_done    = tick && (sub == bit_last());
  assign frame_end   = (state == ST_STOP) && tick && (sub == stop_len - 1'b1);
  assign boundary    = (state == ST_IDLE) || frame_end;
  assign busy        = (state != ST_IDLE);
  assign idle_launch = launch && (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: line_out = 1'b0;
      ST_DATA:  line_out = shreg[0];
      default:  line_out = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sub      <= '0;
      stop_len <= stop_ticks(2'b11);
      bit_idx  <= '0;
      shreg    <= '1;
    end else if (launch) begin
      state    <= ST_START;
      sub      <= '0;
      bit_idx  <= '0;
      shreg    <= next_char;
      stop_len <= stop_ticks(stop_sel);
    end else if (frame_end) begin
      state <= ST_IDLE;
      sub   <= '0;
    end else if (tick && state != ST_IDLE) begin
      case (state)
        ST_START: begin
          if (bit_done) begin
            state <= ST_DATA;
            sub   <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            sub   <= '0;
            shreg <= {1'b1, shreg[CHAR_W-1:1]};
            if (bit_idx == LAST_IDX) state <= ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: sub <= sub + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tty_fill_tx.sv
module tty_fill_tx
  import tty_fill_tx_pkg::*;
#(
  parameter int CLK_DIV = 22222
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  stop_sel,
  input  logic        fill_en,
  output logic        line_out,
  output logic        busy
);
  logic              tick;
  logic              launch;
  logic              boundary;
  logic              frame_end;
  logic              idle_launch;
  logic [CHAR_W-1:0] next_char;

  tty_fill_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle_launch),
    .tick  (tick)
  );

  tty_fill_char_select i_sel (
    .boundary  (boundary),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .fill_en   (fill_en),
    .launch    (launch),
    .next_char (next_char)
  );

  tty_fill_frame_seq i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .launch      (launch),
    .next_char   (next_char),
    .stop_sel    (stop_sel),
    .line_out    (line_out),
    .busy        (busy),
    .boundary    (boundary),
    .frame_end   (frame_end),
    .idle_launch (idle_launch)
  );

  assign in_ready = boundary;
endmodule

// File: rtl/tty_fill_tx_chk.sv
module tty_fill_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic fill_en,
  input logic line_out,
  input logic busy,
  input logic tick,
  input logic frame_end
);
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_out && in_ready)); // R1

  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line_out); // R5

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(line_out)); // R10

  AST_NO_MIDFRAME_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |-> !in_ready); // R6

  AST_FILL_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && frame_end) |=> (busy && !line_out)); // R7
endmodule

bind tty_fill_tx tty_fill_tx_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .fill_en   (fill_en),
  .line_out  (line_out),
  .busy      (busy),
  .tick      (tick),
  .frame_end (frame_end)
);

// File: tb/test_tty_fill_tx.sv
module test_tty_fill_tx;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic [1:0] stop_sel = 2'b11;
  logic       fill_en = 1'b0;
  logic       in_ready, line_out, busy;

  always #5 clk = ~clk;

  tty_fill_tx #(.CLK_DIV(DIV)) i_tty_fill_tx (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .stop_sel(stop_sel), .fill_en(fill_en),
    .line_out(line_out), .busy(busy)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [4:0] ch;
    longint     gap;
    string      req;
  } exp_t;
  exp_t q[$];

  function automatic int stop_len(input logic [1:0] s);
    int tbl[4] = '{100, 142, 150, 200};
    return tbl[s];
  endfunction

  function automatic longint spacing(input logic [1:0] s);
    return longint'((6 * 100 + stop_len(s)) * DIV);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [4:0] ch, input longint gap, input string req);
    exp_t e;
    e.ch = ch; e.gap = gap; e.req = req;
    q.push_back(e);
  endtask

  task automatic send(input logic [4:0] ch);
    @(negedge clk);
    in_data  = ch;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: decode frames from the line and compare against the scoreboard
  initial begin
    logic   prev;
    longint last_t0;
    longint t0;
    logic [4:0] got;
    exp_t   e;
    last_t0 = 0;
    prev = 1'b1;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (prev && !line_out) begin
        t0 = cyc;
        repeat (150 * DIV) @(negedge clk);
        got[0] = line_out;
        for (int k = 1; k < 5; k++) begin
          repeat (100 * DIV) @(negedge clk);
          got[k] = line_out;
        end
        repeat (100 * DIV) @(negedge clk);
        check(line_out == 1'b1, "R2", "stop pulse level", line_out, 1);
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected frame", got, 0);
        end else begin
          e = q.pop_front();
          check(got == e.ch, e.req, "character", got, e.ch);
          if (e.gap != 0)
            check((t0 - last_t0) == e.gap, "R3 R10", "start spacing",
                  t0 - last_t0, e.gap);
        end
        last_t0 = t0;
        prev = 1'b1;
      end else begin
        prev = line_out;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_out == 1'b1, "R1", "idle line", line_out, 1);
    check(busy == 1'b0, "R1", "idle busy", busy, 0);
    check(in_ready == 1'b1, "R1", "idle ready", in_ready, 1);

    // R2 R5 R6: two characters back to back with 2.0 stop
    stop_sel = 2'b11;
    push(5'b10101, 0, "R2");
    push(5'b01010, spacing(2'b11), "R6");
    send(5'b10101);
    check(busy == 1'b1, "R5", "busy after take", busy, 1);
    check(line_out == 1'b0, "R5", "start bit level", line_out, 0);
    check(in_ready == 1'b0, "R6", "ready mid-frame", in_ready, 0);
    send(5'b01010);
    wait_idle();
    check(q.size() == 0, "R2", "frames pending", q.size(), 0);

    // R3: the other stop lengths
    for (int s = 0; s < 3; s++) begin
      stop_sel = 2'(s);
      push(5'b00001, 0, "R3");
      push(5'b11110, spacing(2'(s)), "R3");
      send(5'b00001);
      send(5'b11110);
      wait_idle();
      @(negedge clk);
      check(line_out == 1'b1, "R1", "line after frames", line_out, 1);
    end

    // R4: stop_sel changed mid-frame is not applied to that frame
    stop_sel = 2'b01;
    push(5'b00111, 0, "R4");
    send(5'b00111);
    stop_sel = 2'b11;
    push(5'b11000, spacing(2'b01), "R4");
    send(5'b11000);
    push(5'b00011, spacing(2'b11), "R4");
    send(5'b00011);
    wait_idle();

    // R7 R8 R9: fill frames, user insertion, fill switched off
    stop_sel = 2'b10;
    push(5'b11111, 0, "R7");
    push(5'b11111, spacing(2'b10), "R7");
    @(negedge clk);
    fill_en = 1'b1;
    repeat (850 * DIV) @(negedge clk);
    check(busy == 1'b1, "R7", "busy during fill", busy, 1);
    push(5'b10010, spacing(2'b10), "R8");
    send(5'b10010);
    push(5'b11111, spacing(2'b10), "R7");
    repeat (850 * DIV) @(negedge clk);
    fill_en = 1'b0;
    wait_idle();
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after fill off", busy, 0);
    repeat (1000 * DIV) @(negedge clk);
    check(line_out == 1'b1, "R9", "line rests mark", line_out, 1);
    check(q.size() == 0, "R9", "frames pending", q.size(), 0);

    report();
  end
endmodule